// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This unit watches a 54-pin input port and records per-pin events in sticky status bits. Each pin may be armed for any mix of six trigger kinds. Four are judged on the fully synchronized pin level: rising edge, falling edge, high level and low level. Two are judged one synchronizer stage earlier, so they react one clock sooner: early rising and early falling. A pin whose armed condition is met sets its status bit. The bit then stays set until software writes a one to it.

The unit synchronizes the raw pin levels itself through a two-flop chain plus a history flop. It exposes a simple word-wide register port: a write strobe, a byte address and write data, with read data returned combinationally for the addressed word. The status bits are grouped into 32-pin banks. The OR of each bank's status drives its own interrupt line, and two further lines carry the OR of every status bit. This gives the interrupt controller a per-bank view and a global view.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset all status bits, all six trigger-enable sets and all four interrupt lines are zero.
- R2: Each trigger kind has one enable word per 32-pin bank. Bank 0 is at the base address and bank 1 at base+4. The bases are 0x4C (rising), 0x58 (falling), 0x64 (high), 0x70 (low), 0x7C (early rising) and 0x88 (early falling). An enable word reads back as written, and bits above pin 53 read as zero.
- R3: With rising enabled, a 0-to-1 pin change presented before clock edge 1 sets the pin's status bit at edge 3 and not before.
- R4: With falling enabled, a 1-to-0 pin change presented before edge 1 sets the status bit at edge 3 and not before.
- R5: With high (or low) level enabled, the bit is set while the synchronized level is high (or low). A clear written while the level still holds leaves the bit set. Once the level is gone, a clear empties it.
- R6: The early rising and early falling kinds set the status bit at edge 2 for a change presented before edge 1, one edge ahead of R3/R4.
- R7: A write to 0x40 (bank 0) or 0x44 (bank 1) clears each status bit whose data bit is 1 and leaves the bits written with 0 unchanged. Without such a write a set bit never drops.
- R8: When a new event and a clear of the same bit fall on the same edge, the bit stays set.
- R9: irq_o[0] is the OR of status bits 0..31, irq_o[1] is the OR of bits 32..53, and irq_o[2] and irq_o[3] are each the OR of all status bits.
- R10: A pin with no trigger kind enabled never sets its status bit, whatever it does.
- R11: status_o always equals the status register, and reads at 0x40 and 0x44 return bank 0 and bank 1 of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 54 | Raw pin levels, synchronized inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| status_o | output | 54 | Sticky event status bits |
| irq_o | output | 4 | Interrupt lines: bank 0, bank 1, all, all |

## Verification
The delicate overlap is a write-one clear landing on the same edge as a fresh detection for the same bit. The bench provokes it twice. First, it times a clear write onto the exact edge where an early-rising edge is recognized. Second, it clears a bit whose high-level condition is still present. In both cases the bit must read as set afterwards, while a later clear with no condition present must empty it. The behavioural model, updated every clock from the stimulus alone, judges every cycle of these overlaps as well as the directed checks.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int unsigned BANK_W     = 32;
    localparam int unsigned NUM_TRIG   = 6;
    localparam int unsigned SET_STRIDE = 12;

    localparam logic [7:0] STATUS_BASE = 8'h40;
    localparam logic [7:0] ENABLE_BASE = 8'h4C;

    // Order fixes the enable word bases: ENABLE_BASE + SET_STRIDE * kind
    typedef enum logic [2:0] {
        TRIG_RISE   = 3'd0,
        TRIG_FALL   = 3'd1,
        TRIG_HIGH   = 3'd2,
        TRIG_LOW    = 3'd3,
        TRIG_ERISE  = 3'd4,
        TRIG_EFALL  = 3'd5
    } trig_e;

    function automatic logic [7:0] enable_base(input int unsigned kind);
        return ENABLE_BASE + 8'(SET_STRIDE * kind);
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int unsigned W = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] stage1_o,
    output logic [W-1:0] stage2_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pins_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign stage1_o = sync_q.s1;
    assign stage2_o = sync_q.s2;
    assign prev_o   = sync_q.s3;

endmodule

// File: rtl/gpio_evt_decode.sv
module gpio_evt_decode
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BIDX_W    = 1
) (
    input  logic [7:0]        addr_i,
    output logic              hit_status_o,
    output logic              hit_enable_o,
    output trig_e             kind_o,
    output logic [BIDX_W-1:0] bank_o
);

    localparam logic [7:0] SPAN = 8'(4 * NUM_BANKS);

    always_comb begin
        logic [7:0] off;
        hit_status_o = 1'b0;
        hit_enable_o = 1'b0;
        kind_o       = TRIG_RISE;
        bank_o       = '0;
        off          = addr_i - STATUS_BASE;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i >= STATUS_BASE && off < SPAN) begin
                hit_status_o = 1'b1;
                bank_o       = BIDX_W'(off >> 2);
            end
            for (int t = 0; t < int'(NUM_TRIG); t++) begin
                off = addr_i - enable_base(unsigned'(t));
                if (addr_i >= enable_base(unsigned'(t)) && off < SPAN) begin
                    hit_enable_o = 1'b1;
                    kind_o       = trig_e'(3'(t));
                    bank_o       = BIDX_W'(off >> 2);
                end
            end
        end
    end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int unsigned W = 54
) (
    input  logic [W-1:0]                stage1_i,
    input  logic [W-1:0]                stage2_i,
    input  logic [W-1:0]                prev_i,
    input  logic [NUM_TRIG-1:0][W-1:0]  en_i,
    output logic [W-1:0]                hit_o
);

    logic [NUM_TRIG-1:0][W-1:0] cond;

    for (genvar t = 0; t < int'(NUM_TRIG); t++) begin : g_kind
        if (t == int'(TRIG_RISE)) begin : g_rise
            assign cond[t] = stage2_i & ~prev_i;
        end else if (t == int'(TRIG_FALL)) begin : g_fall
            assign cond[t] = ~stage2_i & prev_i;
        end else if (t == int'(TRIG_HIGH)) begin : g_high
            assign cond[t] = stage2_i;
        end else if (t == int'(TRIG_LOW)) begin : g_low
            assign cond[t] = ~stage2_i;
        end else if (t == int'(TRIG_ERISE)) begin : g_erise
            assign cond[t] = stage1_i & ~stage2_i;
        end else begin : g_efall
            assign cond[t] = ~stage1_i & stage2_i;
        end
    end

    always_comb begin
        hit_o = '0;
        for (int t = 0; t < int'(NUM_TRIG); t++) begin
            hit_o = hit_o | (cond[t] & en_i[t]);
        end
    end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                bus_wr_i,
    input  logic [7:0]          bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_PINS-1:0] status_o,
    output logic [3:0]          irq_o
);

    localparam int unsigned NB     = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int unsigned PW     = NB * BANK_W;
    localparam int unsigned BIDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [PW-1:0] VALID = {PW{1'b1}} >> (PW - NUM_PINS);

    typedef struct packed {
        logic [NUM_TRIG-1:0][PW-1:0] en;
        logic [PW-1:0]               st;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_PINS-1:0] stage1, stage2, prev, hit, en_any;
    logic [NUM_TRIG-1:0][NUM_PINS-1:0] en_pin;
    logic              dec_status, dec_enable;
    trig_e             dec_kind;
    logic [BIDX_W-1:0] dec_bank;
    logic [PW-1:0]     clr;
    logic [NB-1:0]     bank_any;

    gpio_evt_sync #(.W(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_i   (pins_i),
        .stage1_o (stage1),
        .stage2_o (stage2),
        .prev_o   (prev)
    );

    gpio_evt_decode #(.NUM_BANKS(NB), .BIDX_W(BIDX_W)) dec_i (
        .addr_i       (bus_addr_i),
        .hit_status_o (dec_status),
        .hit_enable_o (dec_enable),
        .kind_o       (dec_kind),
        .bank_o       (dec_bank)
    );

    always_comb begin
        en_any = '0;
        for (int t = 0; t < int'(NUM_TRIG); t++) begin
            en_pin[t] = regs_q.en[t][NUM_PINS-1:0];
            en_any    = en_any | en_pin[t];
        end
    end

    gpio_evt_detect #(.W(NUM_PINS)) det_i (
        .stage1_i (stage1),
        .stage2_i (stage2),
        .prev_i   (prev),
        .en_i     (en_pin),
        .hit_o    (hit)
    );

    // Next-state: enable writes, write-one clears, detection has priority
    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (bus_wr_i && dec_status) begin
            clr[dec_bank*BANK_W +: BANK_W] = bus_wdata_i;
        end
        if (bus_wr_i && dec_enable) begin
            regs_d.en[dec_kind][dec_bank*BANK_W +: BANK_W] = bus_wdata_i;
        end
        for (int t = 0; t < int'(NUM_TRIG); t++) begin
            regs_d.en[t] = regs_d.en[t] & VALID;
        end
        regs_d.st = ((regs_q.st & ~clr) | PW'(hit)) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (dec_status) begin
            bus_rdata_o = regs_q.st[dec_bank*BANK_W +: BANK_W];
        end else if (dec_enable) begin
            bus_rdata_o = regs_q.en[dec_kind][dec_bank*BANK_W +: BANK_W];
        end
    end

    for (genvar b = 0; b < int'(NB); b++) begin : g_bank
        assign bank_any[b] = |regs_q.st[b*BANK_W +: BANK_W];
    end

    always_comb begin
        irq_o = '0;
        for (int b = 0; b < int'(NB) && b < 2; b++) begin
            irq_o[b] = bank_any[b];
        end
        irq_o[2] = |regs_q.st;
        irq_o[3] = |regs_q.st;
    end

    assign status_o = regs_q.st[NUM_PINS-1:0];

endmodule

// File: rtl/gpio_evt_unit_chk.sv
module gpio_evt_unit_chk #(
    parameter int unsigned NUM_PINS = 54
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_i,
    input logic [NUM_PINS-1:0] status_o,
    input logic [3:0]          irq_o,
    input logic [NUM_PINS-1:0] en_any
);

    localparam int unsigned LO_TOP = (NUM_PINS > 32) ? 31 : NUM_PINS - 1;

    assert_irq_bank0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] == (|status_o[LO_TOP:0]));

    assert_irq_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o[2] == (|status_o)) && (irq_o[3] == irq_o[2]));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr_i) |-> ((status_o & $past(status_o)) == $past(status_o)));

    assert_enabled_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~$past(status_o) & ~$past(en_any)) == '0);

endmodule

bind gpio_evt_unit gpio_evt_unit_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr_i (bus_wr_i),
    .status_o (status_o),
    .irq_o    (irq_o),
    .en_any   (en_any)
);

// File: tb/gpio_evt_unit_tb.sv
`timescale 1ns/1ps
module gpio_evt_unit_tb_top;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] status;
    logic [3:0]    irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_evt_unit #(.NUM_PINS(NP)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .status_o    (status),
        .irq_o       (irq)
    );

    // Behavioural reference: kind k enable word for bank b at 0x4C + 12k + 4b
    bit [NP-1:0] m_en [6];
    bit [NP-1:0] m_st, m_p1, m_p2, m_p3;

    always @(posedge clk) begin
        bit [NP-1:0] hit, clr;
        bit [63:0]   w64;
        if (!rst_n) begin
            foreach (m_en[k]) m_en[k] = '0;
            m_st = '0; m_p1 = '0; m_p2 = '0; m_p3 = '0;
        end else begin
            hit = (m_en[0] & m_p2 & ~m_p3) | (m_en[1] & ~m_p2 & m_p3)
                | (m_en[2] & m_p2) | (m_en[3] & ~m_p2)
                | (m_en[4] & m_p1 & ~m_p2) | (m_en[5] & ~m_p1 & m_p2);
            clr = '0;
            if (bus_wr) begin
                if (bus_addr == 8'h40) clr[31:0]  = bus_wdata;
                if (bus_addr == 8'h44) clr[53:32] = bus_wdata[21:0];
                for (int k = 0; k < 6; k++) begin
                    w64 = 64'(m_en[k]);
                    if (bus_addr == 8'(8'h4C + 12*k))     w64[31:0]  = bus_wdata;
                    if (bus_addr == 8'(8'h4C + 12*k + 4)) w64[63:32] = bus_wdata;
                    m_en[k] = w64[NP-1:0];
                end
            end
            m_st = (m_st & ~clr) | hit;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pins;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(status == m_st, "R11 status vs model", 64'(status), 64'(m_st));
            chk(irq == {|m_st, |m_st, |m_st[53:32], |m_st[31:0]}, "R9 irq vs model",
                64'(irq), 64'({|m_st, |m_st, |m_st[53:32], |m_st[31:0]}));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk(status == '0, "R1 status", 64'(status), 0);
        chk(irq == '0, "R1 irq", 64'(irq), 0);
        rd(8'h4C, r); chk(r == 0, "R1 rise enable", 64'(r), 0);
        rd(8'h8C, r); chk(r == 0, "R1 early fall enable bank1", 64'(r), 0);

        // R2: enable readback and padding
        wr(8'h5C, 32'hFFFF_FFFF);
        rd(8'h5C, r); chk(r == 32'h003F_FFFF, "R2 pad bits", 64'(r), 64'h3F_FFFF);
        wr(8'h5C, 32'h0);
        rd(8'h5C, r); chk(r == 0, "R2 rewrite", 64'(r), 0);
        wr(8'h4C, 32'h8);
        rd(8'h4C, r); chk(r == 32'h8, "R2 rise bank0", 64'(r), 8);

        // R3: synchronous rising, set at edge 3
        pins[3] = 1'b1;
        idle(1); chk(status[3] == 1'b0, "R3 edge1", 64'(status[3]), 0);
        idle(1); chk(status[3] == 1'b0, "R3 edge2", 64'(status[3]), 0);
        idle(1); chk(status[3] == 1'b1, "R3 edge3", 64'(status[3]), 1);
        chk(irq == 4'b1101, "R9 bank0 irq", 64'(irq), 64'hD);
        rd(8'h40, r); chk(r == 32'h8, "R11 read bank0", 64'(r), 8);

        // R7: write-one clear, zeros ignored
        wr(8'h40, 32'h0);
        chk(status[3] == 1'b1, "R7 zero write keeps", 64'(status[3]), 1);
        wr(8'h40, 32'h8);
        chk(status[3] == 1'b0, "R7 one clears", 64'(status[3]), 0);
        chk(irq == 4'b0000, "R9 irq low", 64'(irq), 0);

        // R4 / R6: sync falling on pin 8, early falling on pin 7
        pins[8:7] = 2'b11;
        idle(4);
        wr(8'h88, 32'h80);
        wr(8'h58, 32'h100);
        pins[8:7] = 2'b00;
        idle(1); chk(status[8:7] == 2'b00, "R6 edge1", 64'(status[8:7]), 0);
        idle(1); chk(status[8:7] == 2'b01, "R6 early falling edge2", 64'(status[8:7]), 1);
        idle(1); chk(status[8:7] == 2'b11, "R4 sync falling edge3", 64'(status[8:7]), 3);
        wr(8'h40, 32'h180);
        chk(status[8:7] == 2'b00, "R7 clear pair", 64'(status[8:7]), 0);

        // R5: high level holds through a clear
        wr(8'h64, 32'h20);
        pins[5] = 1'b1;
        idle(3); chk(status[5] == 1'b1, "R5 high set", 64'(status[5]), 1);
        wr(8'h40, 32'h20);
        chk(status[5] == 1'b1, "R5 held through clear", 64'(status[5]), 1);
        pins[5] = 1'b0;
        idle(3);
        wr(8'h40, 32'h20);
        chk(status[5] == 1'b0, "R5 clear after level gone", 64'(status[5]), 0);

        // R5: low level
        wr(8'h70, 32'h200);
        idle(1); chk(status[9] == 1'b1, "R5 low set", 64'(status[9]), 1);
        wr(8'h70, 32'h0);
        wr(8'h40, 32'h200);
        chk(status[9] == 1'b0, "R5 low cleared", 64'(status[9]), 0);

        // R6 rising + R8: clear on the detection edge
        wr(8'h7C, 32'h40);
        pins[6] = 1'b1;
        idle(1); chk(status[6] == 1'b0, "R6 rise edge1", 64'(status[6]), 0);
        idle(1); chk(status[6] == 1'b1, "R6 early rising edge2", 64'(status[6]), 1);
        pins[6] = 1'b0;
        idle(3);
        pins[6] = 1'b1;
        idle(1);
        bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h40;
        idle(1);
        bus_wr = 1'b0;
        chk(status[6] == 1'b1, "R8 set wins over clear", 64'(status[6]), 1);
        wr(8'h40, 32'h40);
        chk(status[6] == 1'b0, "R7 clear with no event", 64'(status[6]), 0);

        // R9 / R11: bank 1 pin 40
        wr(8'h80, 32'h100);
        pins[40] = 1'b1;
        idle(2);
        chk(status[40] == 1'b1, "R6 bank1 early rise", 64'(status[40]), 1);
        chk(irq == 4'b1110, "R9 bank1 irq", 64'(irq), 64'hE);
        rd(8'h44, r); chk(r == 32'h100, "R11 read bank1", 64'(r), 64'h100);
        wr(8'h44, 32'h100);
        chk(status == '0, "R7 bank1 clear", 64'(status), 0);

        // R10: unarmed pin does nothing
        pins[12] = 1'b1; idle(4);
        pins[12] = 1'b0; idle(4);
        chk(status == '0, "R10 unarmed pin", 64'(status), 0);
        rd(8'h40, r); chk(r == 0, "R10 bank0 read", 64'(r), 0);

        idle(2);
        finish_run();
    end

endmodule